// File: doc/BRIEF.md
# Undocumented-Opcode Combined Logic Unit

This block evaluates the combined-function operations of an 8-bit accumulator processor. These are the opcodes that fuse an AND with a shift, a rotate, a subtract, a load or a store. The processor core presents its accumulator, index X, index Y and stack pointer. It also presents the memory operand, the high byte of the effective base address, the carry and decimal flags, and a 4-bit operation code. One clock edge later the unit returns new A, X and SP values, each with its own update strobe. It also returns a memory write value with a write strobe, and the C, Z, N and V flags, each with its own update enable.

The core owns bus timing, addressing and read-modify-write sequencing. This unit only turns one operand set into one result set per cycle. Register outputs whose strobe is low carry the input value unchanged. Flag outputs whose enable is low read 0. The memory data output reads 0 whenever its write strobe is low.

Top module: `ulo_top`

## Requirements
- R1: Code 1 (and-shift): T = A & M. A becomes T >> 1 and C = T[0]. N is cleared and Z = (A == 0). Enables are set for A, C, Z and N.
- R2: Code 2 (and-carry-copy): A becomes A & M. N = A[7], Z = (A == 0), and C equals N. Enables are set for A, C, Z and N.
- R3: Code 3 (and-rotate) with the decimal input 0: R = {carry-in, (A & M)[7:1]} goes to A. N = R[7], Z = (R == 0), C = R[6] and V = R[6] ^ R[5]. Enables are set for A, C, Z, N and V.
- R4: Code 3 with the decimal input 1: N equals carry-in, and Z is taken from R before any correction. V is set when bit 6 of R differs from bit 6 of A & M.
- R5: Code 3 with the decimal input 1 corrects R before writing A. If R[3:0] + R[0] > 5, the low nibble gets +6 modulo 16. Then, if the high nibble plus bit 4 exceeds 5, the high nibble gets +6 modulo 16 and C = 1. Otherwise C = 0.
- R6: Code 4 (masked subtract): T = A & X. X becomes (T − M) mod 256 and C = (T ≥ M). N and Z are taken from the new X. Enables are set for X, C, Z and N.
- R7: Codes 5, 6 and 7 write (A & X), Y or X respectively, ANDed with (baseHi + 1) mod 256. The memory write strobe is set and no register or flag enable is set.
- R8: Code 8 (stack transfer store) sets SP to 0x100 | (A & X) with its strobe. It writes (A & X) & ((baseHi + 1) mod 256) to memory.
- R9: Code 9 (stack masked load): V = M & SP. A and X both take V, and SP takes 0x100 | V. N and Z are taken from V.
- R10: Code 10 (immediate combine): A becomes (A | 0xEE) & M and X copies it. N and Z are taken from A.
- R11: Code 11 (decrement-compare): D = (M − 1) mod 256 is written to memory. C = (A ≥ D), and N and Z come from (A − D) mod 256. Enables are set for C, Z and N.
- R12: Codes 0 and 12–15 set no strobe or enable. A, X and SP pass through unchanged, and the flags and memory data read 0.
- R13: All outputs are registered one cycle after the inputs. An active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 4 | Operation code |
| accIn | input | 8 | Accumulator |
| idxXIn | input | 8 | Index X |
| idxYIn | input | 8 | Index Y |
| stkIn | input | 8 | Stack pointer low byte |
| memIn | input | 8 | Memory operand |
| baseHi | input | 8 | High byte of base address |
| carryIn | input | 1 | Carry flag |
| decimalIn | input | 1 | Decimal mode flag |
| accOut | output | 8 | New accumulator |
| accWe | output | 1 | Accumulator update strobe |
| idxXOut | output | 8 | New index X |
| idxXWe | output | 1 | Index X update strobe |
| stkOut | output | 9 | New stack pointer, bit 8 set |
| stkWe | output | 1 | Stack pointer update strobe |
| memOut | output | 8 | Memory write value |
| memWe | output | 1 | Memory write strobe |
| carryOut | output | 1 | Carry result |
| carryWe | output | 1 | Carry update enable |
| zeroOut | output | 1 | Zero result |
| zeroWe | output | 1 | Zero update enable |
| negOut | output | 1 | Negative result |
| negWe | output | 1 | Negative update enable |
| ovfOut | output | 1 | Overflow result |
| ovfWe | output | 1 | Overflow update enable |

## Verification
The assertions assume that every input is a known value at each rising edge. They check the registered copy of the operation code, the decimal flag and the base high byte against the results registered in the same cycle. They therefore need the inputs held stable around the edge. The stimulus changes inputs only on the falling edge. It draws each operand from the full 8-bit range, each flag from both values and the code from all sixteen encodings. Directed vectors reach the decimal rotate correction paths, the equal and borrow cases of the subtract, a base high byte of 0xFF, and a decrement of zero.

// File: rtl/ulo_pkg.sv
`timescale 1ns/1ps
package ulo_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;
  localparam int SP_W   = BYTE_W + 1;
  localparam int NIB_W  = BYTE_W / 2;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [NIB_W-1:0]  nib_t;

  localparam logic [OP_W-1:0] OP_NONE    = 4'd0;
  localparam logic [OP_W-1:0] OP_ANDSHR  = 4'd1;
  localparam logic [OP_W-1:0] OP_ANDCPY  = 4'd2;
  localparam logic [OP_W-1:0] OP_ANDROT  = 4'd3;
  localparam logic [OP_W-1:0] OP_MASKSUB = 4'd4;
  localparam logic [OP_W-1:0] OP_STAXHI  = 4'd5;
  localparam logic [OP_W-1:0] OP_STYHI   = 4'd6;
  localparam logic [OP_W-1:0] OP_STXHI   = 4'd7;
  localparam logic [OP_W-1:0] OP_STKXFER = 4'd8;
  localparam logic [OP_W-1:0] OP_STKLOAD = 4'd9;
  localparam logic [OP_W-1:0] OP_IMMCOMB = 4'd10;
  localparam logic [OP_W-1:0] OP_DECCMP  = 4'd11;
  localparam logic [OP_W-1:0] OP_LAST    = OP_DECCMP;

  typedef enum logic [2:0] {
    SRC_KEEP, SRC_SHR, SRC_CPY, SRC_ROT, SRC_SUB, SRC_STK, SRC_IMM, SRC_DEC
  } src_e;

  typedef enum logic [1:0] { MEM_AX, MEM_Y, MEM_X, MEM_DEC } memSel_e;

  typedef struct packed {
    logic    aEn;
    logic    xEn;
    logic    spEn;
    logic    memWe;
    logic    cEn;
    logic    zEn;
    logic    nEn;
    logic    vEn;
    src_e    src;
    memSel_e memSel;
    logic    spFromAx;
  } strobe_t;
endpackage

// File: rtl/ulo_ctrl.sv
`timescale 1ns/1ps
module ulo_ctrl
  import ulo_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output strobe_t         st
);
  always_comb begin
    st = '0;
    case (opSel)
      OP_ANDSHR: begin
        st.aEn = 1'b1; st.cEn = 1'b1; st.zEn = 1'b1; st.nEn = 1'b1;
        st.src = SRC_SHR;
      end
      OP_ANDCPY: begin
        st.aEn = 1'b1; st.cEn = 1'b1; st.zEn = 1'b1; st.nEn = 1'b1;
        st.src = SRC_CPY;
      end
      OP_ANDROT: begin
        st.aEn = 1'b1; st.cEn = 1'b1; st.zEn = 1'b1; st.nEn = 1'b1;
        st.vEn = 1'b1; st.src = SRC_ROT;
      end
      OP_MASKSUB: begin
        st.xEn = 1'b1; st.cEn = 1'b1; st.zEn = 1'b1; st.nEn = 1'b1;
        st.src = SRC_SUB;
      end
      OP_STAXHI: begin
        st.memWe = 1'b1; st.memSel = MEM_AX;
      end
      OP_STYHI: begin
        st.memWe = 1'b1; st.memSel = MEM_Y;
      end
      OP_STXHI: begin
        st.memWe = 1'b1; st.memSel = MEM_X;
      end
      OP_STKXFER: begin
        st.memWe = 1'b1; st.memSel = MEM_AX;
        st.spEn = 1'b1; st.spFromAx = 1'b1;
      end
      OP_STKLOAD: begin
        st.aEn = 1'b1; st.xEn = 1'b1; st.spEn = 1'b1;
        st.zEn = 1'b1; st.nEn = 1'b1; st.src = SRC_STK;
      end
      OP_IMMCOMB: begin
        st.aEn = 1'b1; st.xEn = 1'b1; st.zEn = 1'b1; st.nEn = 1'b1;
        st.src = SRC_IMM;
      end
      OP_DECCMP: begin
        st.memWe = 1'b1; st.memSel = MEM_DEC;
        st.cEn = 1'b1; st.zEn = 1'b1; st.nEn = 1'b1; st.src = SRC_DEC;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ulo_datapath.sv
`timescale 1ns/1ps
module ulo_datapath
  import ulo_pkg::*;
(
  input  strobe_t         st,
  input  byte_t           aIn,
  input  byte_t           xIn,
  input  byte_t           yIn,
  input  byte_t           spIn,
  input  byte_t           mIn,
  input  byte_t           baseHi,
  input  logic            cIn,
  input  logic            decIn,
  output byte_t           aNext,
  output byte_t           xNext,
  output logic [SP_W-1:0] spNext,
  output byte_t           memData,
  output logic            cNext,
  output logic            zNext,
  output logic            nNext,
  output logic            vNext
);
  byte_t andAm, andAx, hiMask, shrVal, rotVal, lowFixed, decFixed, rotRes;
  byte_t subVal, stkVal, immVal, decVal, cmpVal, nzByte, storeRaw;
  logic  subBorrow, cmpBorrow, lowAdj, highAdj;
  logic  rotC, rotV, cRaw;

  assign andAm  = aIn & mIn;
  assign andAx  = aIn & xIn;
  assign hiMask = baseHi + byte_t'(1);

  // shift and rotate paths
  assign shrVal = andAm >> 1;
  assign rotVal = {cIn, andAm[BYTE_W-1:1]};

  // decimal correction of the rotated value, low nibble then high nibble
  assign lowAdj   = ({1'b0, rotVal[NIB_W-1:0]} + {{NIB_W{1'b0}}, rotVal[0]}) > (NIB_W+1)'(5);
  assign lowFixed = {rotVal[BYTE_W-1:NIB_W],
                     lowAdj ? rotVal[NIB_W-1:0] + nib_t'(6) : rotVal[NIB_W-1:0]};
  assign highAdj  = ({1'b0, lowFixed[BYTE_W-1:NIB_W]} + {{NIB_W{1'b0}}, lowFixed[NIB_W]})
                    > (NIB_W+1)'(5);
  assign decFixed = {highAdj ? lowFixed[BYTE_W-1:NIB_W] + nib_t'(6) : lowFixed[BYTE_W-1:NIB_W],
                     lowFixed[NIB_W-1:0]};

  assign rotRes = decIn ? decFixed : rotVal;
  assign rotC   = decIn ? highAdj : rotVal[6];
  assign rotV   = decIn ? (rotVal[6] ^ andAm[6]) : (rotVal[6] ^ rotVal[5]);

  // masked subtract and decrement-compare
  assign {subBorrow, subVal} = {1'b0, andAx} - {1'b0, mIn};
  assign decVal              = mIn - byte_t'(1);
  assign {cmpBorrow, cmpVal} = {1'b0, aIn} - {1'b0, decVal};

  assign stkVal = mIn & spIn;
  assign immVal = (aIn | 8'hEE) & mIn;

  always_comb begin
    aNext  = aIn;
    xNext  = xIn;
    nzByte = '0;
    cRaw   = 1'b0;
    case (st.src)
      SRC_SHR: begin aNext = shrVal; nzByte = shrVal; cRaw = andAm[0]; end
      SRC_CPY: begin aNext = andAm;  nzByte = andAm;  cRaw = andAm[BYTE_W-1]; end
      SRC_ROT: begin aNext = rotRes; nzByte = rotVal; cRaw = rotC; end
      SRC_SUB: begin xNext = subVal; nzByte = subVal; cRaw = ~subBorrow; end
      SRC_STK: begin aNext = stkVal; xNext = stkVal; nzByte = stkVal; end
      SRC_IMM: begin aNext = immVal; xNext = immVal; nzByte = immVal; end
      SRC_DEC: begin nzByte = cmpVal; cRaw = ~cmpBorrow; end
      default: ;
    endcase
    if (!st.aEn) aNext = aIn;
    if (!st.xEn) xNext = xIn;
  end

  always_comb begin
    case (st.memSel)
      MEM_AX:  storeRaw = andAx & hiMask;
      MEM_Y:   storeRaw = yIn & hiMask;
      MEM_X:   storeRaw = xIn & hiMask;
      default: storeRaw = decVal;
    endcase
  end

  assign memData = st.memWe ? storeRaw : '0;

  always_comb begin
    if (!st.spEn)        spNext = {1'b1, spIn};
    else if (st.spFromAx) spNext = {1'b1, andAx};
    else                 spNext = {1'b1, stkVal};
  end

  assign cNext = st.cEn & cRaw;
  assign zNext = st.zEn & (nzByte == '0);
  assign nNext = st.nEn & nzByte[BYTE_W-1];
  assign vNext = st.vEn & rotV;
endmodule

// File: rtl/ulo_top.sv
`timescale 1ns/1ps
module ulo_top
  import ulo_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opSel,
  input  logic [7:0]      accIn,
  input  logic [7:0]      idxXIn,
  input  logic [7:0]      idxYIn,
  input  logic [7:0]      stkIn,
  input  logic [7:0]      memIn,
  input  logic [7:0]      baseHi,
  input  logic            carryIn,
  input  logic            decimalIn,
  output logic [7:0]      accOut,
  output logic            accWe,
  output logic [7:0]      idxXOut,
  output logic            idxXWe,
  output logic [SP_W-1:0] stkOut,
  output logic            stkWe,
  output logic [7:0]      memOut,
  output logic            memWe,
  output logic            carryOut,
  output logic            carryWe,
  output logic            zeroOut,
  output logic            zeroWe,
  output logic            negOut,
  output logic            negWe,
  output logic            ovfOut,
  output logic            ovfWe
);
  strobe_t         st;
  byte_t           aNext, xNext, memData;
  logic [SP_W-1:0] spNext;
  logic            cNext, zNext, nNext, vNext;
  logic [OP_W-1:0] opQ;
  logic            decQ;
  byte_t           maskQ;

  ulo_ctrl ctrl_i (.opSel(opSel), .st(st));

  ulo_datapath dp_i (
    .st(st), .aIn(accIn), .xIn(idxXIn), .yIn(idxYIn), .spIn(stkIn),
    .mIn(memIn), .baseHi(baseHi), .cIn(carryIn), .decIn(decimalIn),
    .aNext(aNext), .xNext(xNext), .spNext(spNext), .memData(memData),
    .cNext(cNext), .zNext(zNext), .nNext(nNext), .vNext(vNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accOut <= '0; accWe <= 1'b0; idxXOut <= '0; idxXWe <= 1'b0;
      stkOut <= '0; stkWe <= 1'b0; memOut <= '0; memWe <= 1'b0;
      carryOut <= 1'b0; carryWe <= 1'b0; zeroOut <= 1'b0; zeroWe <= 1'b0;
      negOut <= 1'b0; negWe <= 1'b0; ovfOut <= 1'b0; ovfWe <= 1'b0;
      opQ <= OP_NONE; decQ <= 1'b0; maskQ <= '0;
    end else begin
      accOut <= aNext;  accWe <= st.aEn;
      idxXOut <= xNext; idxXWe <= st.xEn;
      stkOut <= spNext; stkWe <= st.spEn;
      memOut <= memData; memWe <= st.memWe;
      carryOut <= cNext; carryWe <= st.cEn;
      zeroOut <= zNext;  zeroWe <= st.zEn;
      negOut <= nNext;   negWe <= st.nEn;
      ovfOut <= vNext;   ovfWe <= st.vEn;
      opQ <= opSel; decQ <= decimalIn; maskQ <= baseHi + byte_t'(1);
    end
  end

  AST_UNUSED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (opQ == OP_NONE || opQ > OP_LAST) |->
      !(accWe | idxXWe | stkWe | memWe | carryWe | zeroWe | negWe | ovfWe)); // R12
  AST_SHR_NEG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (opQ == OP_ANDSHR) |-> (negWe && !negOut && !accOut[7])); // R1
  AST_CARRY_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (opQ == OP_ANDCPY) |-> (carryOut == negOut)); // R2
  AST_ROT_BIN_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (opQ == OP_ANDROT && !decQ) |->
      (ovfOut == (accOut[6] ^ accOut[5]) && carryOut == accOut[6])); // R3
  AST_STORE_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (opQ >= OP_STAXHI && opQ <= OP_STKXFER) |->
      (memWe && (memOut & ~maskQ) == '0)); // R7
  AST_STK_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    stkWe |-> (stkOut[8] && (opQ == OP_STKXFER || opQ == OP_STKLOAD))); // R8
  AST_DEC_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (opQ == OP_DECCMP) |-> (memWe && carryWe && !accWe)); // R11
endmodule

// File: tb/ulo_top_tb.sv
`timescale 1ns/1ps
module ulo_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opSel = '0;
  logic [7:0] accIn = '0, idxXIn = '0, idxYIn = '0, stkIn = '0, memIn = '0, baseHi = '0;
  logic       carryIn = 1'b0, decimalIn = 1'b0;
  logic [7:0] accOut, idxXOut, memOut;
  logic [8:0] stkOut;
  logic accWe, idxXWe, stkWe, memWe, carryOut, carryWe, zeroOut, zeroWe;
  logic negOut, negWe, ovfOut, ovfWe;
  int   nChecks = 0, nFails = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  ulo_top dut_i (.*);

  function automatic logic [44:0] refModel(int op, int a, int x, int y, int sp, int m,
                                           int hi, int c, int d);
    int ra = a, rx = x, rsp = 256 + sp, md = 0, mask = (hi + 1) & 255;
    int aw = 0, xw = 0, sw = 0, mw = 0;
    int fc = 0, fz = 0, fn = 0, fv = 0, ce = 0, ze = 0, ne = 0, ve = 0;
    int t, v;
    case (op)
      1: begin t = a & m; fc = t & 1; ra = t >> 1; fn = 0; fz = (ra == 0);
         aw = 1; ce = 1; ze = 1; ne = 1; end
      2: begin ra = a & m; fn = ra >> 7; fz = (ra == 0); fc = fn;
         aw = 1; ce = 1; ze = 1; ne = 1; end
      3: begin
        t = a & m; v = (t | (c << 8)) >> 1; fn = c; fz = (v == 0);
        aw = 1; ce = 1; ze = 1; ne = 1; ve = 1;
        if (d != 0) begin
          fv = ((v ^ t) >> 6) & 1;
          if (((v & 15) + (v & 1)) > 5) v = (v & 240) | ((v + 6) & 15);
          if (((v & 240) + (v & 16)) > 80) begin v = (v & 15) | ((v + 96) & 240); fc = 1; end
          else fc = 0;
        end else begin
          fc = (v >> 6) & 1; fv = ((v >> 6) ^ (v >> 5)) & 1;
        end
        ra = v;
      end
      4: begin t = a & x; fc = (t >= m); rx = (t - m) & 255; fn = rx >> 7; fz = (rx == 0);
         xw = 1; ce = 1; ze = 1; ne = 1; end
      5: begin md = a & x & mask; mw = 1; end
      6: begin md = y & mask; mw = 1; end
      7: begin md = x & mask; mw = 1; end
      8: begin rsp = 256 | (a & x); sw = 1; md = a & x & mask; mw = 1; end
      9: begin v = m & sp; ra = v; rx = v; rsp = 256 | v; fn = v >> 7; fz = (v == 0);
         aw = 1; xw = 1; sw = 1; ze = 1; ne = 1; end
      10: begin ra = (a | 238) & m; rx = ra; fn = ra >> 7; fz = (ra == 0);
          aw = 1; xw = 1; ze = 1; ne = 1; end
      11: begin v = (m - 1) & 255; md = v; mw = 1; fc = (a >= v); t = (a - v) & 255;
          fn = t >> 7; fz = (t == 0); ce = 1; ze = 1; ne = 1; end
      default: ;
    endcase
    return {ra[7:0], 1'(aw), rx[7:0], 1'(xw), rsp[8:0], 1'(sw), md[7:0], 1'(mw),
            1'(fc), 1'(ce), 1'(fz), 1'(ze), 1'(fn), 1'(ne), 1'(fv), 1'(ve)};
  endfunction

  function automatic string reqTag(int op, int d);
    case (op)
      1: return "R1";
      2: return "R2";
      3: return (d != 0) ? "R4/R5" : "R3";
      4: return "R6";
      5, 6, 7: return "R7";
      8: return "R8";
      9: return "R9";
      10: return "R10";
      11: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [44:0] dutVec();
    return {accOut, accWe, idxXOut, idxXWe, stkOut, stkWe, memOut, memWe,
            carryOut, carryWe, zeroOut, zeroWe, negOut, negWe, ovfOut, ovfWe};
  endfunction

  task automatic runVec(int op, int a, int x, int y, int sp, int m, int hi, int c, int d);
    logic [44:0] exp;
    @(negedge clk);
    opSel = 4'(op); accIn = 8'(a); idxXIn = 8'(x); idxYIn = 8'(y); stkIn = 8'(sp);
    memIn = 8'(m); baseHi = 8'(hi); carryIn = 1'(c); decimalIn = 1'(d);
    exp = refModel(op, a & 255, x & 255, y & 255, sp & 255, m & 255, hi & 255, c & 1, d & 1);
    @(posedge clk); #1;  // R13: result registered at this edge
    nChecks++;
    if (dutVec() !== exp) begin
      nFails++;
      $display("FAIL %s op=%0d a=%h x=%h m=%h c=%0d d=%0d actual=%h expected=%h",
               reqTag(op, d), op, a & 255, x & 255, m & 255, c & 1, d & 1, dutVec(), exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #10;
    nChecks++;  // R13: reset clears outputs
    if (dutVec() !== '0) begin
      nFails++;
      $display("FAIL R13 reset actual=%h expected=0", dutVec());
    end
    @(negedge clk); rstN = 1'b1;
    // directed corner cases
    runVec(3, 8'hFF, 0, 0, 0, 8'hFF, 0, 1, 1);   // R5 both nibble fixes
    runVec(3, 8'h0F, 0, 0, 0, 8'h0B, 0, 0, 1);   // R5 low fix only
    runVec(3, 8'h00, 0, 0, 0, 8'hFF, 0, 0, 1);   // R4 zero result
    runVec(3, 8'hC0, 0, 0, 0, 8'hFF, 0, 1, 0);   // R3
    runVec(3, 8'h40, 0, 0, 0, 8'h40, 0, 0, 1);   // R4 V from bit 6
    runVec(1, 8'h01, 0, 0, 0, 8'hFF, 0, 0, 0);   // R1 zero with carry
    runVec(2, 8'h80, 0, 0, 0, 8'hF0, 0, 0, 0);   // R2
    runVec(4, 8'hF0, 8'h3C, 0, 0, 8'h30, 0, 0, 0); // R6 equal
    runVec(4, 8'h01, 8'h01, 0, 0, 8'h02, 0, 1, 0); // R6 borrow
    runVec(5, 8'hFF, 8'hFF, 0, 0, 0, 8'hFF, 0, 0); // R7 mask 0
    runVec(6, 0, 0, 8'hA5, 0, 0, 8'h0E, 0, 0);     // R7
    runVec(7, 0, 8'h5A, 0, 0, 0, 8'h7F, 0, 0);     // R7
    runVec(8, 8'h3C, 8'hF6, 0, 8'h11, 0, 8'h12, 0, 0); // R8
    runVec(9, 0, 0, 0, 8'hF0, 8'h9F, 0, 0, 0);     // R9
    runVec(10, 8'h11, 0, 0, 0, 8'hFF, 0, 0, 0);    // R10
    runVec(11, 8'hFF, 0, 0, 0, 8'h00, 0, 0, 0);    // R11 decrement of zero
    runVec(11, 8'h05, 0, 0, 0, 8'h06, 0, 0, 0);    // R11 equal
    for (int op = 12; op < 16; op++) runVec(op, 8'h77, 8'h66, 8'h55, 8'h44, 8'h33, 0, 1, 1); // R12
    runVec(0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 0, 1, 0); // R12
    // constrained random sweep of every code
    for (int i = 0; i < 4000; i++)
      runVec(i % 16, $urandom & 255, $urandom & 255, $urandom & 255, $urandom & 255,
             $urandom & 255, $urandom & 255, $urandom & 1, $urandom & 1);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule